// File: doc/BRIEF.md
# Two-Level Interrupt Entry and Return Sequencer

This block steers the program counter of a small accumulator-style microcontroller core when an interrupt is entered or left. The core raises a strobe at each instruction boundary. At that point the block checks a high-priority request line and a low-priority request line against two enable bits that it holds itself. When it accepts a request, it saves the working, status and bank registers into shadow registers on the same clock edge. It then offers the current program counter to an external hardware stack and redirects execution to the vector for that priority.

A return-from-interrupt request makes the block pull the return address from the stack and redirect execution there. It re-enables whatever the matching entry masked. If the fast option is set, it also hands the shadow values back to the core so the core can restore its registers.

The stack sits outside the block and is reached over two valid/ready channels. The push channel carries the return address. On it the block holds valid and data steady until the stack takes the word with ready. The pop channel has the block raise valid and wait for ready. In the ready cycle the stack must present the popped address on `pop_data`. On both channels the block keeps `busy` high while it waits, and the core must hold off the next instruction boundary until `busy` falls.

Top module: `irq_vector_unit`

## Requirements
- R1: Reset clears both enables and the shadows. In the first cycle after reset is released, `pc_load` is 1 and `pc_next` is 0x0000, and `busy` is high for that cycle only.
- R2: When the block is idle and `boundary`, `irq_hi` and `en_hi` are all 1, the request is accepted. From the next cycle `push_valid` is 1 and `push_data` holds the `pc_in` of the accept cycle. In the cycle `push_ready` is 1, `pc_load` is 1 with `pc_next` = 0x0008.
- R3: A low-priority request is accepted the same way when `irq_lo` and `en_lo` are 1 and no high-priority request is accepted. Its push completes with `pc_next` = 0x0018.
- R4: When both requests qualify in the same boundary cycle, the high-priority one is taken.
- R5: A high-priority entry clears `en_hi` and `en_lo` at the accept edge. A low-priority entry clears only `en_lo`. So a high-priority request can enter during a low-priority handler, but not the reverse.
- R6: At the accept edge of any entry, `shd_w`, `shd_status` and `shd_bank` take `wreg_in`, `status_in` and `bank_in`.
- R7: While `push_valid` is 1 and `push_ready` is 0, `push_valid` and `push_data` stay unchanged and `pc_load` stays 0.
- R8: `ret_req` at an idle boundary, with no entry accepted, starts a return. `pop_valid` is 1 from the next cycle. In the cycle `pop_ready` is 1, `pc_load` is 1 with `pc_next` = `pop_data`. At that edge the enables are updated:
  - If the return leaves a high-priority handler, `en_hi` is set and `en_lo` gets the value it had before that entry.
  - Otherwise `en_lo` is set.
- R9: `restore_valid` is 1 only in the pop handshake cycle of a return whose `ret_fast` was 1 at the boundary. It then qualifies the shadow outputs as restore values.
- R10: Requests are ignored, leaving enables, shadows and channels unchanged, when `boundary` is 0, when `busy` is 1, or when the matching enable is 0.
- R11: When an entry and `ret_req` qualify in the same boundary cycle, the entry is taken and the return is dropped.
- R12: `en_wr` loads `en_hi_d` and `en_lo_d` into the enables at the next edge. It does so only while the block is idle and no entry or return is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe from the core |
| irq_hi | input | 1 | High-priority request |
| irq_lo | input | 1 | Low-priority request |
| ret_req | input | 1 | Return-from-interrupt request |
| ret_fast | input | 1 | Return also restores the shadowed registers |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_hi_d | input | 1 | New high-priority enable value |
| en_lo_d | input | 1 | New low-priority enable value |
| pc_in | input | PC_W | Current program counter |
| wreg_in | input | DW | Working register value |
| status_in | input | DW | Status register value |
| bank_in | input | DW | Bank select register value |
| en_hi | output | 1 | High-priority enable |
| en_lo | output | 1 | Low-priority enable |
| busy | output | 1 | Sequencer not idle; core must stall |
| pc_load | output | 1 | Redirect the program counter |
| pc_next | output | PC_W | Redirect target |
| push_valid | output | 1 | Return address offered to the stack |
| push_ready | input | 1 | Stack accepts the pushed word |
| push_data | output | PC_W | Return address |
| pop_valid | output | 1 | Pop requested from the stack |
| pop_ready | input | 1 | Stack supplies the popped word |
| pop_data | input | PC_W | Popped return address |
| shd_w | output | DW | Shadow of the working register |
| shd_status | output | DW | Shadow of the status register |
| shd_bank | output | DW | Shadow of the bank register |
| restore_valid | output | 1 | Shadow values are to be restored now |

## Verification
Two pairs of functions can land in the same cycle.

- **Entry and return at one boundary.** The bench raises `ret_req` together with `irq_hi` at a single boundary. It expects a push toward 0x0008, and no pop until a later boundary.
- **Both priorities at one boundary.** The bench raises both request lines in one boundary cycle and expects the vector 0x0008.

A behavioural model runs alongside the design for many thousand randomised cycles, and its outputs are compared every cycle. In that run the two pairs above arise freely, and so do stalls on the stack channels.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {SQ_START, SQ_IDLE, SQ_PUSH, SQ_POP} seq_state_t;
  typedef enum logic [1:0] {TK_NONE, TK_HI, TK_LO, TK_RET} take_t;
  localparam int unsigned NSHADOW = 3;
endpackage

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
(
  input  logic  idle,
  input  logic  boundary,
  input  logic  irq_hi,
  input  logic  irq_lo,
  input  logic  en_hi,
  input  logic  en_lo,
  input  logic  ret_req,
  output take_t take
);
  logic gate;
  assign gate = idle & boundary;

  always_comb begin
    take = TK_NONE;
    if (gate) begin
      if (irq_hi && en_hi)      take = TK_HI;   // high level wins ties
      else if (irq_lo && en_lo) take = TK_LO;
      else if (ret_req)         take = TK_RET;  // entry beats a return
    end
  end
endmodule

// File: rtl/irqv_enables.sv
module irqv_enables
  import irqv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  take_t take,
  input  logic  idle,
  input  logic  ret_done,
  input  logic  en_wr,
  input  logic  en_hi_d,
  input  logic  en_lo_d,
  output logic  en_hi,
  output logic  en_lo
);
  logic in_hi_q;
  logic in_lo_q;
  logic saved_lo_q;
  logic write_ok;

  assign write_ok = idle && (take == TK_NONE) && en_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_hi      <= 1'b0;
      en_lo      <= 1'b0;
      in_hi_q    <= 1'b0;
      in_lo_q    <= 1'b0;
      saved_lo_q <= 1'b0;
    end else if (take == TK_HI) begin
      saved_lo_q <= en_lo;
      en_hi      <= 1'b0;
      en_lo      <= 1'b0;
      in_hi_q    <= 1'b1;
    end else if (take == TK_LO) begin
      en_lo      <= 1'b0;
      in_lo_q    <= 1'b1;
    end else if (ret_done) begin
      if (in_hi_q) begin
        in_hi_q <= 1'b0;
        en_hi   <= 1'b1;
        en_lo   <= saved_lo_q;
      end else begin
        in_lo_q <= 1'b0;
        en_lo   <= 1'b1;
      end
    end else if (write_ok) begin
      en_hi <= en_hi_d;
      en_lo <= en_lo_d;
    end
  end
endmodule

// File: rtl/irqv_shadow.sv
module irqv_shadow #(
  parameter int unsigned DW = 8,
  parameter int unsigned NR = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic [NR-1:0][DW-1:0] live,
  output logic [NR-1:0][DW-1:0] saved
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)       saved[g] <= '0;
      else if (capture) saved[g] <= live[g];
    end
  end
endmodule

// File: rtl/irqv_seq.sv
module irqv_seq
  import irqv_pkg::*;
#(
  parameter int unsigned     PC_W   = 21,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] HI_VEC  = PC_W'(8),
  parameter logic [PC_W-1:0] LO_VEC  = PC_W'(24)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  take_t           take,
  input  logic            ret_fast,
  input  logic [PC_W-1:0] pc_in,
  input  logic            push_ready,
  input  logic            pop_ready,
  input  logic [PC_W-1:0] pop_data,
  output logic            idle,
  output logic            busy,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_next,
  output logic            push_valid,
  output logic [PC_W-1:0] push_data,
  output logic            pop_valid,
  output logic            ret_done,
  output logic            restore_valid
);
  seq_state_t state_q;
  logic       lvl_hi_q;
  logic       fast_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_START;
      push_data <= '0;
      lvl_hi_q  <= 1'b0;
      fast_q    <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_START: state_q <= SQ_IDLE;
        SQ_IDLE: begin
          if (take == TK_HI || take == TK_LO) begin
            state_q   <= SQ_PUSH;
            push_data <= pc_in;
            lvl_hi_q  <= (take == TK_HI);
          end else if (take == TK_RET) begin
            state_q <= SQ_POP;
            fast_q  <= ret_fast;
          end
        end
        SQ_PUSH: if (push_ready) state_q <= SQ_IDLE;
        SQ_POP:  if (pop_ready)  state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign idle       = (state_q == SQ_IDLE);
  assign busy       = !idle;
  assign push_valid = (state_q == SQ_PUSH);
  assign pop_valid  = (state_q == SQ_POP);
  assign ret_done   = pop_valid && pop_ready;
  assign restore_valid = ret_done && fast_q;

  always_comb begin
    pc_load = 1'b0;
    pc_next = RST_VEC;
    unique case (state_q)
      SQ_START: pc_load = 1'b1;
      SQ_PUSH: begin
        pc_load = push_ready;
        pc_next = lvl_hi_q ? HI_VEC : LO_VEC;
      end
      SQ_POP: begin
        pc_load = pop_ready;
        pc_next = pop_data;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int unsigned     PC_W   = 21,
  parameter int unsigned     DW     = 8,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] HI_VEC  = PC_W'(8),
  parameter logic [PC_W-1:0] LO_VEC  = PC_W'(24)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary,
  input  logic            irq_hi,
  input  logic            irq_lo,
  input  logic            ret_req,
  input  logic            ret_fast,
  input  logic            en_wr,
  input  logic            en_hi_d,
  input  logic            en_lo_d,
  input  logic [PC_W-1:0] pc_in,
  input  logic [DW-1:0]   wreg_in,
  input  logic [DW-1:0]   status_in,
  input  logic [DW-1:0]   bank_in,
  output logic            en_hi,
  output logic            en_lo,
  output logic            busy,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_next,
  output logic            push_valid,
  input  logic            push_ready,
  output logic [PC_W-1:0] push_data,
  output logic            pop_valid,
  input  logic            pop_ready,
  input  logic [PC_W-1:0] pop_data,
  output logic [DW-1:0]   shd_w,
  output logic [DW-1:0]   shd_status,
  output logic [DW-1:0]   shd_bank,
  output logic            restore_valid
);
  take_t take;
  logic  idle;
  logic  ret_done;
  logic  entry;
  logic [NSHADOW-1:0][DW-1:0] live_regs;
  logic [NSHADOW-1:0][DW-1:0] shadow_regs;

  assign entry     = (take == TK_HI) || (take == TK_LO);
  assign live_regs = {bank_in, status_in, wreg_in};
  assign shd_w      = shadow_regs[0];
  assign shd_status = shadow_regs[1];
  assign shd_bank   = shadow_regs[2];

  irqv_arbiter u_arb (
    .idle(idle), .boundary(boundary), .irq_hi(irq_hi), .irq_lo(irq_lo),
    .en_hi(en_hi), .en_lo(en_lo), .ret_req(ret_req), .take(take)
  );

  irqv_enables u_en (
    .clk(clk), .rst_n(rst_n), .take(take), .idle(idle), .ret_done(ret_done),
    .en_wr(en_wr), .en_hi_d(en_hi_d), .en_lo_d(en_lo_d),
    .en_hi(en_hi), .en_lo(en_lo)
  );

  irqv_shadow #(.DW(DW), .NR(NSHADOW)) u_shd (
    .clk(clk), .rst_n(rst_n), .capture(entry), .live(live_regs), .saved(shadow_regs)
  );

  irqv_seq #(.PC_W(PC_W), .RST_VEC(RST_VEC), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .ret_fast(ret_fast), .pc_in(pc_in),
    .push_ready(push_ready), .pop_ready(pop_ready), .pop_data(pop_data),
    .idle(idle), .busy(busy), .pc_load(pc_load), .pc_next(pc_next),
    .push_valid(push_valid), .push_data(push_data), .pop_valid(pop_valid),
    .ret_done(ret_done), .restore_valid(restore_valid)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int unsigned     PC_W   = 21,
  parameter int unsigned     DW     = 8,
  parameter logic [PC_W-1:0] HI_VEC = PC_W'(8),
  parameter logic [PC_W-1:0] LO_VEC = PC_W'(24)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            boundary,
  input logic            irq_hi,
  input logic            en_hi,
  input logic            en_lo,
  input logic            busy,
  input logic [DW-1:0]   wreg_in,
  input logic [DW-1:0]   shd_w,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_next,
  input logic            push_valid,
  input logic            push_ready,
  input logic [PC_W-1:0] push_data,
  input logic            pop_valid,
  input logic            pop_ready,
  input logic [PC_W-1:0] pop_data,
  input logic            restore_valid
);
  AST_PUSH_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && pc_load |-> (pc_next == HI_VEC || pc_next == LO_VEC)); // R2
  AST_HI_MASKS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && pc_load && pc_next == HI_VEC |-> !en_hi && !en_lo); // R5
  AST_LO_MASKS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && pc_load && pc_next == LO_VEC |-> !en_lo); // R5
  AST_SHADOW_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && boundary && irq_hi && en_hi |=> shd_w == $past(wreg_in)); // R6
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_data)); // R7
  AST_NO_EARLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |-> !pc_load); // R7
  AST_POP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid && pop_ready |-> pc_load && pc_next == pop_data); // R8
  AST_RESTORE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> pop_valid && pop_ready); // R9
  AST_NO_BOUNDARY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !boundary |=> !push_valid && !pop_valid); // R10
endmodule

bind irq_vector_unit irqv_checker #(.PC_W(PC_W), .DW(DW), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .irq_hi(irq_hi), .en_hi(en_hi),
  .en_lo(en_lo), .busy(busy), .wreg_in(wreg_in), .shd_w(shd_w), .pc_load(pc_load),
  .pc_next(pc_next), .push_valid(push_valid), .push_ready(push_ready),
  .push_data(push_data), .pop_valid(pop_valid), .pop_ready(pop_ready),
  .pop_data(pop_data), .restore_valid(restore_valid)
);

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
  localparam int PC_W = 21;
  localparam int DW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 0, irq_hi = 0, irq_lo = 0, ret_req = 0, ret_fast = 0;
  logic en_wr = 0, en_hi_d = 0, en_lo_d = 0;
  logic [PC_W-1:0] pc_in = '0;
  logic [DW-1:0] wreg_in = '0, status_in = '0, bank_in = '0;
  logic push_ready = 1, pop_ready = 1;
  logic [PC_W-1:0] pop_data = '0;
  logic en_hi, en_lo, busy, pc_load, push_valid, pop_valid, restore_valid;
  logic [PC_W-1:0] pc_next, push_data;
  logic [DW-1:0] shd_w, shd_status, shd_bank;

  always #2 clk = ~clk;

  irq_vector_unit #(.PC_W(PC_W), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .irq_hi(irq_hi), .irq_lo(irq_lo),
    .ret_req(ret_req), .ret_fast(ret_fast), .en_wr(en_wr), .en_hi_d(en_hi_d),
    .en_lo_d(en_lo_d), .pc_in(pc_in), .wreg_in(wreg_in), .status_in(status_in),
    .bank_in(bank_in), .en_hi(en_hi), .en_lo(en_lo), .busy(busy), .pc_load(pc_load),
    .pc_next(pc_next), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data(pop_data), .shd_w(shd_w), .shd_status(shd_status), .shd_bank(shd_bank),
    .restore_valid(restore_valid)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference model state: 0 start, 1 idle, 2 pushing, 3 popping
  int m_st;
  bit m_eh, m_el, m_inh, m_inl, m_savl, m_lvl, m_fast;
  int m_pc;
  int m_sw, m_ss, m_sb;

  task automatic chk(string tag, int act, int exp, string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_eh = 0; m_el = 0; m_inh = 0; m_inl = 0; m_savl = 0;
    m_lvl = 0; m_fast = 0; m_pc = 0; m_sw = 0; m_ss = 0; m_sb = 0;
  endtask

  task automatic compare();
    string t;
    bit eload;
    int enext;
    t = (m_st == 0) ? "R1" : cur_tag;
    eload = (m_st == 0) || (m_st == 2 && push_ready) || (m_st == 3 && pop_ready);
    chk(t, busy, m_st != 1, "busy");
    chk(t, pc_load, eload, "pc_load");
    chk(t, push_valid, m_st == 2, "push_valid");
    chk(t, pop_valid, m_st == 3, "pop_valid");
    if (eload) begin
      if (m_st == 0) chk("R1", pc_next, 0, "pc_next reset");
      else if (m_st == 2) begin
        enext = m_lvl ? 'h8 : 'h18;
        if (cur_tag == "R4") chk("R4", pc_next, enext, "pc_next tie");
        else if (m_lvl) chk("R2", pc_next, enext, "pc_next high");
        else chk("R3", pc_next, enext, "pc_next low");
      end else chk("R8", pc_next, pop_data, "pc_next return");
    end
    if (m_st == 2) chk("R7", push_data, m_pc, "push_data");
    chk(t, en_hi, m_eh, "en_hi");
    chk(t, en_lo, m_el, "en_lo");
    chk("R6", shd_w, m_sw, "shd_w");
    chk("R6", shd_status, m_ss, "shd_status");
    chk("R6", shd_bank, m_sb, "shd_bank");
    chk("R9", restore_valid, (m_st == 3) && pop_ready && m_fast, "restore_valid");
  endtask

  task automatic model_step();
    bit th, tl;
    case (m_st)
      0: m_st = 1;
      1: begin
        th = boundary && irq_hi && m_eh;
        tl = boundary && irq_lo && m_el && !th;
        if (th || tl) begin
          m_sw = wreg_in; m_ss = status_in; m_sb = bank_in;
          m_pc = pc_in; m_lvl = th; m_st = 2;
          if (th) begin m_savl = m_el; m_eh = 0; m_el = 0; m_inh = 1; end
          else begin m_el = 0; m_inl = 1; end
        end else if (boundary && ret_req) begin
          m_st = 3; m_fast = ret_fast;
        end else if (en_wr) begin
          m_eh = en_hi_d; m_el = en_lo_d;
        end
      end
      2: if (push_ready) m_st = 1;
      default: if (pop_ready) begin
        m_st = 1;
        if (m_inh) begin m_inh = 0; m_eh = 1; m_el = m_savl; end
        else begin m_inl = 0; m_el = 1; end
      end
    endcase
  endtask

  task automatic step();
    #1;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic quiet();
    boundary = 0; irq_hi = 0; irq_lo = 0; ret_req = 0; ret_fast = 0; en_wr = 0;
  endtask

  task automatic regs(int seed);
    pc_in = PC_W'(seed * 37 + 5);
    wreg_in = DW'(seed + 1); status_in = DW'(seed * 3); bank_in = DW'(seed ^ 8'h5a);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", en_hi, 0, "en_hi in reset");
    chk("R1", en_lo, 0, "en_lo in reset");
    rst_n = 1;
    step(); step();
    // R12: software loads the enables
    cur_tag = "R12";
    en_wr = 1; en_hi_d = 1; en_lo_d = 1; step(); quiet(); step();
    // R2 with push back-pressure (R7)
    cur_tag = "R2";
    regs(1); boundary = 1; irq_hi = 1; step(); quiet();
    cur_tag = "R7"; push_ready = 0; step(); step(); step();
    push_ready = 1; step(); step();
    // R9: fast return with pop stall
    cur_tag = "R9";
    boundary = 1; ret_req = 1; ret_fast = 1; step(); quiet();
    pop_ready = 0; step(); pop_ready = 1; pop_data = 21'h1236; step(); step();
    // R3 then high preempts low handler (R5), then nested returns (R8)
    cur_tag = "R3";
    regs(2); boundary = 1; irq_lo = 1; step(); quiet(); step(); step();
    cur_tag = "R5";
    regs(3); boundary = 1; irq_hi = 1; irq_lo = 1; step(); quiet(); step(); step();
    cur_tag = "R5";
    regs(4); boundary = 1; irq_lo = 1; step(); quiet(); step();
    cur_tag = "R8";
    pop_data = 21'h0400; boundary = 1; ret_req = 1; step(); quiet(); step(); step();
    pop_data = 21'h0a00; boundary = 1; ret_req = 1; step(); quiet(); step(); step();
    // R4: simultaneous requests
    cur_tag = "R4";
    regs(5); boundary = 1; irq_hi = 1; irq_lo = 1; step(); quiet(); step(); step();
    cur_tag = "R8";
    boundary = 1; ret_req = 1; step(); quiet(); step(); step();
    // R10: no boundary, disabled levels, busy
    cur_tag = "R10";
    regs(6); irq_hi = 1; irq_lo = 1; step(); step();
    quiet(); en_wr = 1; en_hi_d = 0; en_lo_d = 0; step(); quiet();
    regs(7); boundary = 1; irq_hi = 1; irq_lo = 1; step(); step(); quiet();
    en_wr = 1; en_hi_d = 1; en_lo_d = 1; step(); quiet();
    // R11: entry and return in one boundary
    cur_tag = "R11";
    regs(8); boundary = 1; irq_hi = 1; ret_req = 1; step(); quiet();
    step(); step(); step();
    // randomised traffic
    cur_tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      boundary = ($urandom % 3) != 0;
      irq_hi = ($urandom % 5) == 0;
      irq_lo = ($urandom % 3) == 0;
      ret_req = ($urandom % 4) == 0;
      ret_fast = $urandom % 2;
      en_wr = ($urandom % 9) == 0;
      en_hi_d = $urandom % 2; en_lo_d = $urandom % 2;
      push_ready = ($urandom % 3) != 0;
      pop_ready = ($urandom % 3) != 0;
      pop_data = PC_W'($urandom);
      regs(int'($urandom % 200));
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule